// File: doc/BRIEF.md
# Flat Panel Pixel Output Stage

This block is the last stage of a display back-end before a flat panel's digital input port. It accepts 24-bit RGB pixels as a valid/ready stream in the back-end clock domain, with a marker on the first pixel of a frame and a marker on the last pixel. It forwards them to the panel either one pixel per back-end cycle or packed two at a time. It also produces the control levels that a clock pad needs to form the panel clock. The pixel layout is red in bits 23:16, green in bits 15:8 and blue in bits 7:0.

Three control inputs (enable, power-down, blank) select one of four global modes:

- **power-down** wipes the latched configuration and silences every output.
- **disable** swallows incoming pixels and keeps the outputs in reset.
- **blank** substitutes a programmable colour for every pixel.
- **normal** passes pixels through.

Apart from power-down, a mode change takes effect only on the pixel that carries the frame-start marker. The same applies to single/double packing and to clock polarity, so a frame is never emitted in a mixed mode.

The back-pressure rule is simple because a panel cannot stall. `in_ready` is high in every mode except power-down. A beat transfers on any cycle with `in_valid` and `in_ready` both high. The output side has no ready signal. `out_valid` marks each cycle that carries a new pixel or pixel pair.

Top module: `panel_out_if`

## Requirements
- R1: The mode is decoded with priority. `cfg_power_down`=1 gives power-down whatever the other bits are. Otherwise `cfg_enable`=0 gives disable. Otherwise `cfg_blank_mode` chooses blank (1) or normal (0).
- R2: Power-down acts at the next clock edge, even in mid-frame. While it is held:
  - every output is 0 and `in_ready` is 0;
  - the latched configuration returns to its defaults (disable, single pixel, no inversion).
  
  After release, the outputs therefore stay 0 until a pixel with `in_sof` arrives.
- R3: In disable mode, pixels are accepted and discarded, and all outputs stay 0.
- R4: In blank mode, every emitted pixel is replaced by the blank colour: `cfg_blank_r` in bits 23:16, `cfg_blank_g` in bits 15:8 and `cfg_blank_b` in bits 7:0 of each 24-bit half.
- R5: Mode, packing (`cfg_double`) and polarity (`cfg_clk_inv`) are sampled only on an accepted beat with `in_sof`=1. Changes at any other time have no effect on the frame in progress.
- R6: In single pixel mode, an accepted pixel appears on `out_data[23:0]` with `out_valid`=1 one cycle after acceptance, and `out_data[47:24]` is 0.
- R7: In double pixel mode, pairing works as follows:
  - The first pixel after a frame start goes to `out_data[23:0]` and the second to `out_data[47:24]`.
  - `out_valid` rises one cycle after the second pixel is accepted.
  - A frame start restarts pairing and drops any unpaired pixel.
- R8: In double mode, if a pixel with `in_eof` lands in the lower half, the pair is emitted at once with the blank colour in the upper half, and `out_odd_err` is 1 for that output cycle only.
- R9: In double mode, `out_pclk_lvl` shows the panel clock level. It equals `cfg_clk_inv` (as latched) after the first pixel of a pair and its inverse after a pair is emitted. It restarts at each frame start. In single mode it is 0.
- R10: `out_pclk_dbl` and `out_pclk_inv` report the latched packing and polarity in normal and blank modes. They are 0 in disable and power-down.
- R11: `in_ready` is 1 except during power-down. Beats offered while `in_ready` is 0 are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Back-end pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_eof | input | 1 | Beat is the last pixel of a frame |
| in_pix | input | 24 | Input RGB pixel |
| cfg_enable | input | 1 | Output enable control bit |
| cfg_power_down | input | 1 | Power-down control bit |
| cfg_blank_mode | input | 1 | Blank select control bit |
| cfg_double | input | 1 | 1 = two pixels per panel clock |
| cfg_clk_inv | input | 1 | 1 = invert panel clock |
| cfg_blank_r | input | 8 | Blank colour red |
| cfg_blank_g | input | 8 | Blank colour green |
| cfg_blank_b | input | 8 | Blank colour blue |
| out_valid | output | 1 | New pixel or pair on out_data |
| out_data | output | 48 | Panel data, lower pixel in bits 23:0 |
| out_odd_err | output | 1 | Frame ended on an unpaired pixel |
| out_pclk_lvl | output | 1 | Divided panel clock level (double mode) |
| out_pclk_dbl | output | 1 | Pad should run the panel clock at half rate |
| out_pclk_inv | output | 1 | Pad should invert the panel clock |

## Verification
Pixels carry a per-beat ramp, so a dropped, duplicated or swapped pixel shows up in the data comparison. Beats are fed both back to back and with idle gaps, which separates output timing tied to acceptance from timing tied to the clock. Double mode is tried with even frames, an odd frame and a frame cut short by a new frame start, which tells correct pairing apart from stale phase or a lost pad. Control bits are flipped mid-frame, and power-down is asserted mid-frame and then released without a frame start, which shows whether configuration is latched only at frame boundaries and cleared by power-down.

// File: rtl/panel_out_pkg.sv
package panel_out_pkg;

  typedef enum logic [1:0] {
    MD_OFF   = 2'd0,
    MD_BLANK = 2'd1,
    MD_NORM  = 2'd2
  } omode_e;

  // Priority decode; power-down is handled separately by its own path.
  function automatic omode_e pick_mode(input logic en, input logic pd, input logic bl);
    if (pd || !en) return MD_OFF;
    else if (bl)   return MD_BLANK;
    else           return MD_NORM;
  endfunction

endpackage

// File: rtl/pof_ctrl.sv
module pof_ctrl
  import panel_out_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pd,
  input  logic   take_sof,
  input  logic   cfg_enable,
  input  logic   cfg_blank_mode,
  input  logic   cfg_double,
  input  logic   cfg_clk_inv,
  output omode_e eff_mode,
  output logic   eff_dbl,
  output logic   eff_inv,
  output omode_e cur_mode,
  output logic   cur_dbl,
  output logic   cur_inv
);

  omode_e mode_q;
  logic   dbl_q, inv_q;

  always_comb begin
    if (take_sof) begin
      eff_mode = pick_mode(cfg_enable, pd, cfg_blank_mode);
      eff_dbl  = cfg_double;
      eff_inv  = cfg_clk_inv;
    end else begin
      eff_mode = mode_q;
      eff_dbl  = dbl_q;
      eff_inv  = inv_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pd) begin
      mode_q <= MD_OFF;
      dbl_q  <= 1'b0;
      inv_q  <= 1'b0;
    end else if (take_sof) begin
      mode_q <= eff_mode;
      dbl_q  <= eff_dbl;
      inv_q  <= eff_inv;
    end
  end

  assign cur_mode = mode_q;
  assign cur_dbl  = dbl_q;
  assign cur_inv  = inv_q;

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_sof || pd) |=> $stable({mode_q, dbl_q, inv_q}));

endmodule

// File: rtl/pof_pack.sv
module pof_pack
  import panel_out_pkg::*;
#(
  parameter int PIX_W = 24,
  localparam int OUT_W = 2 * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  omode_e           eff_mode,
  input  logic             eff_dbl,
  input  logic             eff_inv,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [PIX_W-1:0] blank_pix,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             odd_err,
  output logic             pclk_lvl
);

  logic             ph_q, ph_in;
  logic [PIX_W-1:0] lo_q, pix_sel;

  always_comb begin
    ph_in   = sof ? 1'b0 : ph_q;
    pix_sel = (eff_mode == MD_BLANK) ? blank_pix : pix_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pd) begin
      ph_q      <= 1'b0;
      lo_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      odd_err   <= 1'b0;
      pclk_lvl  <= 1'b0;
    end else if (beat) begin
      if (eff_mode == MD_OFF) begin
        ph_q      <= 1'b0;
        out_valid <= 1'b0;
        out_data  <= '0;
        odd_err   <= 1'b0;
        pclk_lvl  <= 1'b0;
      end else if (!eff_dbl) begin
        ph_q      <= 1'b0;
        out_valid <= 1'b1;
        out_data  <= {{PIX_W{1'b0}}, pix_sel};
        odd_err   <= 1'b0;
        pclk_lvl  <= 1'b0;
      end else if (!ph_in) begin
        lo_q <= pix_sel;
        if (eof) begin
          ph_q      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= {blank_pix, pix_sel};
          odd_err   <= 1'b1;
          pclk_lvl  <= ~eff_inv;
        end else begin
          ph_q      <= 1'b1;
          out_valid <= 1'b0;
          odd_err   <= 1'b0;
          pclk_lvl  <= eff_inv;
        end
      end else begin
        ph_q      <= 1'b0;
        out_valid <= 1'b1;
        out_data  <= {pix_sel, lo_q};
        odd_err   <= 1'b0;
        pclk_lvl  <= ~eff_inv;
      end
    end else begin
      out_valid <= 1'b0;
      odd_err   <= 1'b0;
    end
  end

  // R8
  odd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !pd && eff_mode != MD_OFF && eff_dbl && !ph_in && eof)
    |=> (odd_err && out_valid && out_data[OUT_W-1:PIX_W] == $past(blank_pix)));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |=> !odd_err || $past(beat));

endmodule

// File: rtl/panel_out_if.sv
module panel_out_if
  import panel_out_pkg::*;
#(
  parameter int COMP_W = 8,
  localparam int PIX_W = 3 * COMP_W,
  localparam int OUT_W = 2 * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              cfg_enable,
  input  logic              cfg_power_down,
  input  logic              cfg_blank_mode,
  input  logic              cfg_double,
  input  logic              cfg_clk_inv,
  input  logic [COMP_W-1:0] cfg_blank_r,
  input  logic [COMP_W-1:0] cfg_blank_g,
  input  logic [COMP_W-1:0] cfg_blank_b,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_odd_err,
  output logic              out_pclk_lvl,
  output logic              out_pclk_dbl,
  output logic              out_pclk_inv
);

  logic             beat, take_sof, active;
  logic [PIX_W-1:0] blank_pix;
  omode_e           eff_mode, cur_mode;
  logic             eff_dbl, eff_inv, cur_dbl, cur_inv;

  assign in_ready  = ~cfg_power_down;
  assign beat      = in_valid & in_ready;
  assign take_sof  = beat & in_sof;
  assign blank_pix = {cfg_blank_r, cfg_blank_g, cfg_blank_b};

  pof_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pd(cfg_power_down), .take_sof(take_sof),
    .cfg_enable(cfg_enable), .cfg_blank_mode(cfg_blank_mode),
    .cfg_double(cfg_double), .cfg_clk_inv(cfg_clk_inv),
    .eff_mode(eff_mode), .eff_dbl(eff_dbl), .eff_inv(eff_inv),
    .cur_mode(cur_mode), .cur_dbl(cur_dbl), .cur_inv(cur_inv)
  );

  pof_pack #(.PIX_W(PIX_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .pd(cfg_power_down), .beat(beat),
    .sof(in_sof), .eof(in_eof), .eff_mode(eff_mode), .eff_dbl(eff_dbl),
    .eff_inv(eff_inv), .pix_in(in_pix), .blank_pix(blank_pix),
    .out_valid(out_valid), .out_data(out_data), .odd_err(out_odd_err),
    .pclk_lvl(out_pclk_lvl)
  );

  assign active       = (cur_mode != MD_OFF);
  assign out_pclk_dbl = active & cur_dbl;
  assign out_pclk_inv = active & cur_inv;

  // R2
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_power_down |=> (!out_valid && out_data == '0 && !out_odd_err &&
                        !out_pclk_lvl && !out_pclk_dbl && !out_pclk_inv));

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MD_OFF) |-> (!out_valid && !out_pclk_lvl && !out_odd_err));

  // R6
  single_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cur_dbl) |-> (out_data[OUT_W-1:PIX_W] == '0));

  // R4
  blank_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur_mode == MD_BLANK && !cur_dbl)
    |-> (out_data[PIX_W-1:0] == $past(blank_pix)));

endmodule

// File: tb/panel_out_if_tb_top.sv
`timescale 1ns/1ps
module panel_out_if_tb_top;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [23:0] in_pix = '0;
  logic        cfg_enable = 0, cfg_power_down = 0, cfg_blank_mode = 0;
  logic        cfg_double = 0, cfg_clk_inv = 0;
  logic [7:0]  cfg_blank_r = 8'h11, cfg_blank_g = 8'h22, cfg_blank_b = 8'h33;
  logic        in_ready, out_valid, out_odd_err, out_pclk_lvl, out_pclk_dbl, out_pclk_inv;
  logic [47:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  panel_out_if dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eof(in_eof), .in_pix(in_pix),
    .cfg_enable(cfg_enable), .cfg_power_down(cfg_power_down),
    .cfg_blank_mode(cfg_blank_mode), .cfg_double(cfg_double),
    .cfg_clk_inv(cfg_clk_inv), .cfg_blank_r(cfg_blank_r),
    .cfg_blank_g(cfg_blank_g), .cfg_blank_b(cfg_blank_b),
    .out_valid(out_valid), .out_data(out_data), .out_odd_err(out_odd_err),
    .out_pclk_lvl(out_pclk_lvl), .out_pclk_dbl(out_pclk_dbl),
    .out_pclk_inv(out_pclk_inv)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: 0 = disable, 1 = blank, 2 = normal
  int          m_mode = 0;
  bit          m_dbl = 0, m_inv = 0, m_pd = 0;
  logic [23:0] pend[$];
  logic        e_valid = 0, e_err = 0, e_lvl = 0;
  logic [47:0] e_data = '0;

  always @(posedge clk) begin
    logic [23:0] bc, px;
    bc = {cfg_blank_r, cfg_blank_g, cfg_blank_b};
    m_pd = 0;
    if (!rst_n || cfg_power_down) begin
      m_pd = cfg_power_down;
      m_mode = 0; m_dbl = 0; m_inv = 0; pend.delete();
      e_valid = 0; e_err = 0; e_lvl = 0; e_data = '0;
    end else if (in_valid) begin
      if (in_sof) begin
        m_mode = !cfg_enable ? 0 : (cfg_blank_mode ? 1 : 2);
        m_dbl = cfg_double; m_inv = cfg_clk_inv;
        pend.delete();
      end
      px = (m_mode == 1) ? bc : in_pix;
      e_err = 0;
      if (m_mode == 0) begin
        e_valid = 0; e_data = '0; e_lvl = 0; pend.delete();
      end else if (!m_dbl) begin
        e_valid = 1; e_data = {24'h0, px}; e_lvl = 0;
      end else if (pend.size() == 0) begin
        if (in_eof) begin
          e_valid = 1; e_data = {bc, px}; e_err = 1; e_lvl = !m_inv;
        end else begin
          pend.push_back(px); e_valid = 0; e_lvl = m_inv;
        end
      end else begin
        e_data = {px, pend.pop_front()}; e_valid = 1; e_lvl = !m_inv;
      end
    end else begin
      e_valid = 0; e_err = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    string mt;
    if (m_pd)             mt = "R2";
    else if (m_mode == 0) mt = "R3";
    else if (m_dbl)       mt = (m_mode == 1) ? "R7 R4" : "R7";
    else                  mt = (m_mode == 1) ? "R6 R4" : "R6";
    chk({mt, " R1 R5 out_valid"}, 64'(out_valid), 64'(e_valid));
    chk({mt, " R1 R5 out_data"},  64'(out_data),  64'(e_data));
    chk("R8 out_odd_err",         64'(out_odd_err), 64'(e_err));
    chk("R9 out_pclk_lvl",        64'(out_pclk_lvl), 64'(e_lvl));
    chk("R10 out_pclk_dbl",       64'(out_pclk_dbl), 64'(m_mode != 0 && m_dbl));
    chk("R10 out_pclk_inv",       64'(out_pclk_inv), 64'(m_mode != 0 && m_inv));
    chk("R11 in_ready",           64'(in_ready), 64'(!cfg_power_down));
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  // Sends a frame; gap adds idle cycles, flip_at toggles control bits mid-frame (R5)
  task automatic send(input int n, input bit gap, input logic [23:0] seed,
                      input int flip_at, input bit mark_eof);
    for (int i = 0; i < n; i++) begin
      step();
      if (i == flip_at) begin
        cfg_blank_mode = ~cfg_blank_mode;
        cfg_double = ~cfg_double;
        cfg_clk_inv = ~cfg_clk_inv;
      end
      in_valid = 1; in_sof = (i == 0); in_eof = mark_eof && (i == n - 1);
      in_pix = seed + 24'(i) * 24'h010203;
      if (gap && (i % 2 == 1)) begin
        step(); in_valid = 0; in_sof = 0; in_eof = 0;
      end
    end
    step(); in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R3: reset defaults to disable; frame with enable low is swallowed
    send(4, 0, 24'h100000, -1, 1);
    // R6: normal single, back to back then gapped
    cfg_enable = 1;
    send(6, 0, 24'h0A0B0C, -1, 1);
    send(5, 1, 24'hF00001, -1, 1);
    // R5: control flips mid-frame have no effect until next frame
    send(6, 0, 24'h202020, 2, 1);
    // now blank=1, double=1, inv=1 latch here (R4, R7, R9)
    send(6, 1, 24'h303030, -1, 1);
    // R4 single blank with changing colour
    cfg_double = 0; cfg_blank_r = 8'hA5; cfg_blank_b = 8'h5A;
    send(4, 0, 24'h404040, -1, 1);
    // R7/R8 double normal, even then odd
    cfg_blank_mode = 0; cfg_double = 1; cfg_clk_inv = 0;
    send(8, 0, 24'h010101, -1, 1);
    send(5, 1, 24'h777777, -1, 1);
    // R7: frame cut short on unpaired pixel, then new frame
    send(3, 0, 24'h123456, -1, 0);
    send(4, 0, 24'h654321, -1, 1);
    // R2: power-down mid-frame, release, pixels without frame start
    fork
      send(10, 0, 24'h0F0F0F, -1, 1);
      begin idle(4); cfg_power_down = 1; cfg_blank_mode = 1; idle(3); cfg_power_down = 0; end
    join
    in_valid = 1; in_pix = 24'hABCDEF; idle(4); in_valid = 0;
    // R1: enable low with blank high is still disable
    cfg_enable = 0;
    send(4, 0, 24'h555555, -1, 1);
    // R1: power-down beats everything
    cfg_enable = 1; cfg_power_down = 1;
    send(3, 0, 24'h666666, -1, 1);
    cfg_power_down = 0;
    send(4, 1, 24'h999999, -1, 1);
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule